// File: doc/BRIEF.md
# Power-Gating Retention Sequencer

This controller walks one switchable power domain through shut-down and wake-up from the always-on side of the chip. When sleep is requested, it waits for the retention rail to report a good level. It then issues a one-cycle save strobe to the domain's retention registers and turns off every power-switch segment. On wake-up it turns the switch segments back on one at a time in chain order. Each segment has to acknowledge, and a programmable number of settling cycles has to pass, before the next segment is enabled. This keeps inrush current low. When the primary rail reports fully on, the controller issues a one-cycle restore strobe and raises the ready flag.

If the retention rail drops while the domain is powered down, the retained contents can no longer be trusted. The controller then sets a sticky error flag and wakes the domain at once. It does not issue a restore strobe, so software sees a domain whose non-retained and retained state must both be treated as unknown. All outputs come from registers held in the always-on region. None of them depends on logic inside the switched domain.

Top module: `pgate_seq`

## Requirements
- R1: After reset the domain is taken as powered: `dom_ready`=1, `seg_en` all ones, `save_pulse`=0, `restore_pulse`=0, `err_lost`=0.
- R2: A sleep request issues `save_pulse` only after `ret_rail_ok` has been sampled high. Until then the domain stays fully on (`seg_en` all ones) and no save is issued.
- R3: `restore_pulse` is issued only after `prim_on` has been sampled high following the wake chain. While `prim_on` is low, no restore is issued and `dom_ready` stays low.
- R4: `save_pulse` and `restore_pulse` are each high for exactly one cycle per sleep or wake sequence.
- R5: In the cycle after `save_pulse`, every bit of `seg_en` is low and `dom_ready` is low.
- R6: On wake, segment 0 is enabled first. Segment k (k>0) is enabled only after segment k-1 has acknowledged. A segment that never acknowledges stalls the chain with all later segments off.
- R7: `seg_en[k+1]` rises exactly `settle_cycles`+1 clock cycles after the first cycle in which `seg_ack[k]` is sampled high.
- R8: If `ret_rail_ok` is low while the domain is powered down, `err_lost` goes high. The domain wakes by itself, issues no restore pulse, and becomes ready once `prim_on` is high.
- R9: `err_lost` stays high until the next `save_pulse`, which clears it.
- R10: A sleep request that arrives during wake-up is held. Once the domain has reached the running state it is put back to sleep without a further request.
- R11: `wake_req` has no effect while the domain is running, and `sleep_req` has no effect while it is asleep.
- R12: `dom_ready` is high only when all segments are enabled and the sequencer is in its running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request to power the domain down |
| wake_req | input | 1 | Request to power the domain up |
| ret_rail_ok | input | 1 | Retention rail at its required level |
| prim_on | input | 1 | Primary rail of the domain completely on |
| seg_ack | input | NSEG | Per-segment switch-on acknowledge |
| settle_cycles | input | CW | Settling cycles added after each segment acknowledge |
| save_pulse | output | 1 | One-cycle save strobe to retention registers |
| restore_pulse | output | 1 | One-cycle restore strobe to retention registers |
| seg_en | output | NSEG | Power-switch segment enables, bit 0 first in the chain |
| dom_ready | output | 1 | Domain powered and running |
| err_lost | output | 1 | Sticky: retention rail was lost, retained state invalid |

## Verification
The bench holds the retention rail low across a sleep request to show that the save waits. A design that strobed early would save into a dead rail. It holds `prim_on` low after the chain completes to catch a restore fired into a half-powered domain. It measures the exact cycle gap between each acknowledge and the next enable for two settle values, and it blocks one acknowledge to confirm that the chain stalls instead of switching on all segments at once. It also drops the rail during sleep, which exposes a design that restores corrupt data or clears the error too soon, and it raises sleep during wake-up, which exposes a design that loses the request.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_SAVE_CHK,
    ST_SAVE,
    ST_OFF,
    ST_SLEEP,
    ST_WAKE,
    ST_RST_CHK,
    ST_RESTORE
  } pg_state_t;
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] init,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= init;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/seg_chain.sv
module seg_chain #(
  parameter int NSEG = 4,
  parameter int CW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            run,
  input  logic [NSEG-1:0] seg_ack,
  input  logic [CW-1:0]   settle_cycles,
  output logic [NSEG-1:0] seg_en,
  output logic            done
);
  localparam int IW = (NSEG > 1) ? $clog2(NSEG) : 1;
  localparam logic [IW-1:0] LAST = IW'(NSEG - 1);

  logic [NSEG-1:0] en_q;
  logic [IW-1:0]   idx_q;
  logic [IW-1:0]   idx_nxt;
  logic            timing_q;
  logic            done_q;
  logic            tmr_load;
  logic            tmr_exp;

  assign idx_nxt  = idx_q + 1'b1;
  assign tmr_load = run && !done_q && !timing_q && en_q[idx_q] && seg_ack[idx_q];

  settle_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .init    (settle_cycles),
    .expired (tmr_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '1;
      idx_q    <= '0;
      timing_q <= 1'b0;
      done_q   <= 1'b1;
    end else if (clear) begin
      en_q     <= '0;
      idx_q    <= '0;
      timing_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (run && !done_q) begin
      if (!timing_q) begin
        if (!en_q[idx_q])          en_q[idx_q] <= 1'b1;
        else if (seg_ack[idx_q])   timing_q    <= 1'b1;
      end else if (tmr_exp) begin
        timing_q <= 1'b0;
        if (idx_q == LAST) begin
          done_q <= 1'b1;
        end else begin
          idx_q         <= idx_nxt;
          en_q[idx_nxt] <= 1'b1;
        end
      end
    end
  end

  assign seg_en = en_q;
  assign done   = done_q;
endmodule

// File: rtl/pgate_seq.sv
module pgate_seq
  import pgate_pkg::*;
#(
  parameter int NSEG = 4,
  parameter int CW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_req,
  input  logic            wake_req,
  input  logic            ret_rail_ok,
  input  logic            prim_on,
  input  logic [NSEG-1:0] seg_ack,
  input  logic [CW-1:0]   settle_cycles,
  output logic            save_pulse,
  output logic            restore_pulse,
  output logic [NSEG-1:0] seg_en,
  output logic            dom_ready,
  output logic            err_lost
);
  pg_state_t state_q, state_d;
  logic      pend_q;
  logic      err_q;
  logic      chain_done;
  logic      in_down;
  logic      in_wake;
  logic      rail_lost;

  assign in_down   = (state_q == ST_OFF) || (state_q == ST_SLEEP);
  assign in_wake   = (state_q == ST_WAKE) || (state_q == ST_RST_CHK) || (state_q == ST_RESTORE);
  assign rail_lost = in_down && !ret_rail_ok;

  seg_chain #(.NSEG(NSEG), .CW(CW)) u_chain (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear         (state_q == ST_SAVE),
    .run           (state_q == ST_WAKE),
    .seg_ack       (seg_ack),
    .settle_cycles (settle_cycles),
    .seg_en        (seg_en),
    .done          (chain_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:      if (sleep_req || pend_q) state_d = ST_SAVE_CHK;
      ST_SAVE_CHK: if (ret_rail_ok)         state_d = ST_SAVE;
      ST_SAVE:                              state_d = ST_OFF;
      ST_OFF:      state_d = rail_lost ? ST_WAKE : ST_SLEEP;
      ST_SLEEP:    if (rail_lost || wake_req) state_d = ST_WAKE;
      ST_WAKE:     if (chain_done)          state_d = ST_RST_CHK;
      ST_RST_CHK:  if (prim_on)             state_d = err_q ? ST_RUN : ST_RESTORE;
      ST_RESTORE:                           state_d = ST_RUN;
      default:                              state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RUN)           pend_q <= 1'b0;
      else if (in_wake && sleep_req)   pend_q <= 1'b1;
      if (state_q == ST_SAVE)          err_q  <= 1'b0;
      else if (rail_lost)              err_q  <= 1'b1;
    end
  end

  assign save_pulse    = (state_q == ST_SAVE);
  assign restore_pulse = (state_q == ST_RESTORE);
  assign dom_ready     = (state_q == ST_RUN);
  assign err_lost      = err_q;
endmodule

// File: rtl/pgate_seq_chk.sv
module pgate_seq_chk #(
  parameter int NSEG = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ret_rail_ok,
  input logic            prim_on,
  input logic            save_pulse,
  input logic            restore_pulse,
  input logic [NSEG-1:0] seg_en,
  input logic            dom_ready,
  input logic            err_lost
);
  assert_save_rail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    save_pulse |-> $past(ret_rail_ok));

  assert_restore_prim_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restore_pulse |-> $past(prim_on));

  assert_save_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    save_pulse |=> !save_pulse);

  assert_restore_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restore_pulse |=> !restore_pulse);

  assert_off_after_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
    save_pulse |=> (seg_en == '0) && !dom_ready);

  for (genvar k = 1; k < NSEG; k++) begin : g_order
    assert_chain_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seg_en[k]) |-> seg_en[k-1]);
  end

  assert_no_restore_lost_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_pulse |-> !err_lost);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_lost && !save_pulse |=> err_lost);

  assert_ready_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dom_ready |-> (&seg_en));
endmodule

bind pgate_seq pgate_seq_chk #(.NSEG(NSEG)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ret_rail_ok   (ret_rail_ok),
  .prim_on       (prim_on),
  .save_pulse    (save_pulse),
  .restore_pulse (restore_pulse),
  .seg_en        (seg_en),
  .dom_ready     (dom_ready),
  .err_lost      (err_lost)
);

// File: tb/pgate_seq_bench.sv
`timescale 1ns/1ps
module pgate_seq_bench;
  localparam int NSEG = 4;
  localparam int CW   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sleep_req = 1'b0;
  logic            wake_req = 1'b0;
  logic            ret_rail_ok = 1'b1;
  logic            prim_on = 1'b0;
  logic [NSEG-1:0] seg_ack = '0;
  logic [CW-1:0]   settle_cycles = 4'd2;
  logic            save_pulse, restore_pulse, dom_ready, err_lost;
  logic [NSEG-1:0] seg_en;

  pgate_seq #(.NSEG(NSEG), .CW(CW)) u_pgate_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .ret_rail_ok(ret_rail_ok), .prim_on(prim_on), .seg_ack(seg_ack),
    .settle_cycles(settle_cycles), .save_pulse(save_pulse),
    .restore_pulse(restore_pulse), .seg_en(seg_en), .dom_ready(dom_ready),
    .err_lost(err_lost)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int t = 0;
  int save_cnt = 0, rest_cnt = 0, wide_cnt = 0, ready_rises = 0;
  logic save_prev = 0, rest_prev = 0, ready_prev = 0;
  logic [NSEG-1:0] en_prev = '0, ack_prev = '0, en_d = '0, ack_block = '0;
  logic prim_allow = 1'b1;
  int ack_t [NSEG];
  int en_t  [NSEG];
  bit finished = 0;

  // Monitor and rail/switch model, all at the falling edge.
  always @(negedge clk) begin
    t++;
    if (rst_n) begin
      if (save_pulse) begin save_cnt++; if (save_prev) wide_cnt++; end
      if (restore_pulse) begin rest_cnt++; if (rest_prev) wide_cnt++; end
      if (dom_ready && !ready_prev) ready_rises++;
      for (int k = 0; k < NSEG; k++) begin
        if (seg_ack[k] && !ack_prev[k]) ack_t[k] = t;
        if (seg_en[k] && !en_prev[k])   en_t[k]  = t;
      end
    end
    save_prev = save_pulse; rest_prev = restore_pulse; ready_prev = dom_ready;
    en_prev = seg_en; ack_prev = seg_ack;
    seg_ack = en_d & ~ack_block;
    en_d    = seg_en;
    prim_on = prim_allow & (&seg_ack);
    if (t > 20000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", t, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sleep();
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_req = 1'b1;
    @(negedge clk); wake_req = 1'b0;
  endtask

  task automatic wait_ready(input int lim);
    for (int i = 0; i < lim && !dom_ready; i++) @(negedge clk);
  endtask

  task automatic go_sleep();
    pulse_sleep();
    cyc(6);
  endtask

  task automatic t_reset();
    check(dom_ready == 1'b1, "R1 ready", dom_ready, 1);
    check(seg_en == '1, "R1 seg_en", seg_en, 15);
    check(!save_pulse && !restore_pulse, "R1 strobes", save_pulse, 0);
    check(err_lost == 1'b0, "R1 err", err_lost, 0);
  endtask

  task automatic t_sleep_gated();
    ret_rail_ok = 1'b0;
    pulse_sleep();
    cyc(8);
    check(save_cnt == 0, "R2 no save without rail", save_cnt, 0);
    check(seg_en == '1, "R2 domain stays on", seg_en, 15);
    ret_rail_ok = 1'b1;
    cyc(6);
    check(save_cnt == 1, "R2 save after rail ok", save_cnt, 1);
    check(wide_cnt == 0, "R4 save width", wide_cnt, 0);
    check(seg_en == '0, "R5 all segments off", seg_en, 0);
    check(dom_ready == 1'b0, "R5 not ready", dom_ready, 0);
  endtask

  task automatic t_sleep_ignored();
    pulse_sleep();
    cyc(5);
    check(save_cnt == 1, "R11 sleep in sleep ignored", save_cnt, 1);
    check(seg_en == '0, "R11 still off", seg_en, 0);
  endtask

  task automatic t_wake(input logic [CW-1:0] st);
    int r0;
    r0 = rest_cnt;
    settle_cycles = st;
    prim_allow = 1'b0;
    pulse_wake();
    for (int i = 0; i < 200 && seg_en != '1; i++) @(negedge clk);
    cyc(8);
    check(rest_cnt == r0, "R3 no restore before prim_on", rest_cnt, r0);
    check(dom_ready == 1'b0, "R3 not ready before prim_on", dom_ready, 0);
    for (int k = 0; k + 1 < NSEG; k++)
      check(en_t[k+1] - ack_t[k] == int'(st) + 1, "R7 settle gap",
            en_t[k+1] - ack_t[k], int'(st) + 1);
    check(en_t[0] < en_t[1] && en_t[1] < en_t[2] && en_t[2] < en_t[3],
          "R6 chain order", en_t[3], en_t[0]);
    prim_allow = 1'b1;
    wait_ready(20);
    check(rest_cnt == r0 + 1, "R3 restore after prim_on", rest_cnt, r0 + 1);
    check(wide_cnt == 0, "R4 restore width", wide_cnt, 0);
    check(dom_ready && seg_en == '1, "R12 ready with all on", seg_en, 15);
  endtask

  task automatic t_stall();
    go_sleep();
    settle_cycles = 4'd1;
    ack_block = 4'b0010;
    pulse_wake();
    cyc(30);
    check(seg_en == 4'b0011, "R6 stall at missing ack", seg_en, 3);
    check(dom_ready == 1'b0, "R12 not ready while stalled", dom_ready, 0);
    ack_block = '0;
    wait_ready(100);
    check(dom_ready == 1'b1, "R6 resumes after ack", dom_ready, 1);
  endtask

  task automatic t_rail_loss();
    int r0, s0;
    go_sleep();
    r0 = rest_cnt;
    cyc(3);
    ret_rail_ok = 1'b0;
    cyc(2);
    check(err_lost == 1'b1, "R8 error on rail loss", err_lost, 1);
    ret_rail_ok = 1'b1;
    wait_ready(150);
    check(dom_ready == 1'b1, "R8 auto wake", dom_ready, 1);
    check(rest_cnt == r0, "R8 no restore", rest_cnt, r0);
    cyc(5);
    check(err_lost == 1'b1, "R9 error sticky", err_lost, 1);
    s0 = save_cnt;
    go_sleep();
    check(save_cnt == s0 + 1 && err_lost == 1'b0, "R9 cleared by save", err_lost, 0);
  endtask

  task automatic t_pending();
    int s0, rr0;
    s0 = save_cnt; rr0 = ready_rises;
    pulse_wake();
    cyc(2);
    pulse_sleep();
    for (int i = 0; i < 150 && save_cnt == s0; i++) @(negedge clk);
    cyc(3);
    check(ready_rises == rr0 + 1, "R10 reached run", ready_rises, rr0 + 1);
    check(save_cnt == s0 + 1, "R10 held sleep applied", save_cnt, s0 + 1);
    check(seg_en == '0, "R10 back asleep", seg_en, 0);
  endtask

  task automatic t_wake_ignored();
    int s0;
    pulse_wake();
    wait_ready(150);
    s0 = save_cnt;
    pulse_wake();
    cyc(5);
    check(dom_ready == 1'b1 && seg_en == '1, "R11 wake in run ignored", seg_en, 15);
    check(save_cnt == s0, "R11 no sequence started", save_cnt, s0);
  endtask

  initial begin
    for (int k = 0; k < NSEG; k++) begin ack_t[k] = 0; en_t[k] = 0; end
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_sleep_gated();
    t_sleep_ignored();
    t_wake(4'd2);
    go_sleep();
    t_wake(4'd0);
    t_stall();
    t_rail_loss();
    t_pending();
    t_wake_ignored();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule